// File: doc/BRIEF.md
# Byte-Bus Timekeeping Register Window

This block presents a 32K-byte address space on a byte-wide bus that uses a chip select, an output enable and a write enable. The top eight byte addresses form a window onto a calendar counter that lives outside the block. Every other address reaches a small byte RAM model. The model aliases its upper address bits away, so the bench can show that a RAM location sharing low address bits with a clock register stays apart from it.

The block keeps a user copy of the calendar. While no hold is active, the copy follows the live counter on every clock. Two control bits in the century register change that. The read hold freezes the copy so that software sees one coherent instant while the counter keeps running. The write hold also freezes the copy and lets software load new time fields into it. Clearing the write hold sends those fields to the counter in a single-cycle load pulse.

Three more control bits are handled here. The seconds register holds the oscillator stop bit. The day register holds a frequency-test bit, and its top bit is a read-only battery flag. Bits with no clock meaning are plain storage.

A two-state machine enforces the write strobe rule:
- ST_IDLE moves to ST_WLOCK in the first clock in which chip select and write enable are both low. That is the commit transition: exactly one write is performed.
- ST_WLOCK returns to ST_IDLE once either strobe is high again.

Top module: `rtc_regbus`

## Requirements
- R1: While reset is held, bus_drive is 0, bus_rdata is 0, load_stb is 0 and osc_run is 1.
- R2: bus_drive is 1 exactly when cs_n=0, oe_n=0 and we_n=1. While bus_drive is 0, bus_rdata is 0x00.
- R3: A write episode is a stretch of cycles with cs_n and we_n both low. It commits exactly once, at the first rising clock edge of the episode, using the address and data present at that edge, whatever oe_n is. Data changed later in the same episode is not written.
- R4: Addresses 0x7FF8 to 0x7FFF select the clock registers, with index = addr[2:0]. The index order is 0 century/control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Every other address goes to RAM, which aliases on its low 8 address bits. A RAM write never changes a clock register, and a clock write never changes RAM.
- R5: With both hold bits at 0, each register's time field equals byte i of live_time (bits 8i+7:8i) from the previous clock. The field masks are century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF. A write to a time field without the write hold is overwritten on the next tracking clock.
- R6: While bit 6 of register 0 (read hold) is 1, the time fields keep their captured values. Clearing the bit lets them follow live_time again from the next clock.
- R7: While bit 7 of register 0 (write hold) is 1, the time fields keep the written values. A write to register 0 with bit 7 at 0, while that hold is set, produces a one-cycle load_stb in the clock after the commit. load_time then carries every field under its mask, with register 0's field taken from that write. No other write produces load_stb.
- R8: Bit 7 of register 1 stops the oscillator: osc_run equals the inverse of that bit.
- R9: When bit 6 of register 4 is 1 and the oscillator runs, bit 0 of register 1 as read equals tick512.
- R10: Bit 7 of register 4 as read equals batt_ok. Writes to that bit have no visible effect.
- R11: Bits outside the time fields (all except the control and battery bits) keep the last written value and are not touched by tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not driving |
| bus_drive | output | 1 | High while the block drives read data |
| live_time | input | 64 | Live counter fields, byte i for register i |
| tick512 | input | 1 | 512 Hz square wave from the oscillator divider |
| batt_ok | input | 1 | Battery level good |
| load_stb | output | 1 | One-cycle pulse that loads the counter |
| load_time | output | 64 | Masked field values to load, byte i for register i |
| osc_run | output | 1 | Oscillator enable |

## Verification
A wrong hold bit shows up at the ports in one of two ways. A clock register read stays at an old value after the live counter moves, or it follows the counter while it should be frozen. Either is visible one clock after the change, on the next read. A wrong strobe state shows up as a second commit within one episode, which is caught by reading the address back. A wrong decode shows up as a RAM byte and a clock register that corrupt each other. A load pulse that is wrong in count or content is visible in the cycle after the releasing write.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    localparam int REG_N  = 8;
    localparam int REG_IW = $clog2(REG_N);

    typedef enum logic [REG_IW-1:0] {
        RI_CENT  = 3'd0,
        RI_SEC   = 3'd1,
        RI_MIN   = 3'd2,
        RI_HOUR  = 3'd3,
        RI_DAY   = 3'd4,
        RI_DATE  = 3'd5,
        RI_MONTH = 3'd6,
        RI_YEAR  = 3'd7
    } reg_idx_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WLOCK = 1'b1
    } bus_st_e;

    localparam int BIT_WHOLD   = 7;
    localparam int BIT_RHOLD   = 6;
    localparam int BIT_OSCSTOP = 7;
    localparam int BIT_FTEST   = 6;
    localparam int BIT_BATT    = 7;

    // Bits of each register that belong to the running calendar
    function automatic logic [7:0] field_mask(input logic [REG_IW-1:0] idx);
        logic [7:0] m;
        case (idx)
            RI_CENT:  m = 8'h3F;
            RI_SEC:   m = 8'h7F;
            RI_MIN:   m = 8'h7F;
            RI_HOUR:  m = 8'h3F;
            RI_DAY:   m = 8'h07;
            RI_DATE:  m = 8'h3F;
            RI_MONTH: m = 8'h1F;
            default:  m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rtcb_busfsm.sv
module rtcb_busfsm
    import rtcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    output logic wr_fire
);

    bus_st_e st_q, st_nx;
    logic    wr_lvl;

    assign wr_lvl = !cs_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx   = st_q;
        wr_fire = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_lvl) begin
                    wr_fire = 1'b1;
                    st_nx   = ST_WLOCK;
                end
            end
            ST_WLOCK: begin
                if (!wr_lvl) st_nx = ST_IDLE;
            end
        endcase
    end

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lvl) && wr_lvl) |-> !wr_fire); // R3

endmodule

// File: rtl/rtcb_ram.sv
module rtcb_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/rtcb_regfile.sv
module rtcb_regfile
    import rtcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_IW-1:0] widx,
    input  logic [7:0]        wdata,
    input  logic [REG_IW-1:0] ridx,
    output logic [7:0]        rdata,
    input  logic [8*REG_N-1:0] live_time,
    input  logic              tick512,
    input  logic              batt_ok,
    output logic              load_stb,
    output logic [8*REG_N-1:0] load_time,
    output logic              osc_run
);

    logic [8*REG_N-1:0] ureg_flat;
    logic [8*REG_N-1:0] load_nx;
    logic [7:0]         cent_q, sec_q, day_q, year_q;
    logic               hold, commit;

    assign cent_q = ureg_flat[8*RI_CENT +: 8];
    assign sec_q  = ureg_flat[8*RI_SEC  +: 8];
    assign day_q  = ureg_flat[8*RI_DAY  +: 8];
    assign year_q = ureg_flat[8*RI_YEAR +: 8];

    assign hold    = cent_q[BIT_WHOLD] || cent_q[BIT_RHOLD];
    assign osc_run = !sec_q[BIT_OSCSTOP];
    assign commit  = wr_en && (widx == RI_CENT) && cent_q[BIT_WHOLD] && !wdata[BIT_WHOLD];

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_reg
        localparam logic [7:0] FM = field_mask(REG_IW'(gi));
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (widx == REG_IW'(gi))) begin
                q <= wdata;
            end else if (!hold) begin
                q <= (q & ~FM) | (live_time[8*gi +: 8] & FM);
            end
        end

        assign ureg_flat[8*gi +: 8] = q;
        assign load_nx[8*gi +: 8]   = ((gi == 0) ? wdata : q) & FM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_stb  <= 1'b0;
            load_time <= '0;
        end else begin
            load_stb <= commit;
            if (commit) load_time <= load_nx;
        end
    end

    always_comb begin
        rdata = ureg_flat[{ridx, 3'b000} +: 8];
        if (ridx == RI_DAY) rdata[BIT_BATT] = batt_ok;
        if ((ridx == RI_SEC) && day_q[BIT_FTEST] && !sec_q[BIT_OSCSTOP]) rdata[0] = tick512;
    end

    AST_LOAD_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ($past(cent_q[BIT_WHOLD]) && !cent_q[BIT_WHOLD])); // R7

    AST_RHOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_q[BIT_RHOLD] && !wr_en) |=> $stable(year_q)); // R6

    AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !wr_en) |=> (year_q == $past(live_time[8*RI_YEAR +: 8]))); // R5

endmodule

// File: rtl/rtc_regbus.sv
module rtc_regbus
    import rtcb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               bus_drive,
    input  logic [8*REG_N-1:0] live_time,
    input  logic               tick512,
    input  logic               batt_ok,
    output logic               load_stb,
    output logic [8*REG_N-1:0] load_time,
    output logic               osc_run
);

    localparam int WIN_HI = ADDR_W - 1;
    localparam int WIN_LO = REG_IW;

    logic              wr_fire, clk_sel, reg_we, ram_we;
    logic [7:0]        reg_rd, ram_rd;
    logic [REG_IW-1:0] ridx;

    assign clk_sel   = &bus_addr[WIN_HI:WIN_LO];
    assign ridx      = bus_addr[REG_IW-1:0];
    assign reg_we    = wr_fire && clk_sel;
    assign ram_we    = wr_fire && !clk_sel;
    assign bus_drive = !cs_n && !oe_n && we_n;
    assign bus_rdata = bus_drive ? (clk_sel ? reg_rd : ram_rd) : 8'h00;

    rtcb_busfsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .wr_fire (wr_fire)
    );

    rtcb_ram #(.AW(RAM_AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (bus_addr[RAM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (ram_rd)
    );

    rtcb_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .widx      (ridx),
        .wdata     (bus_wdata),
        .ridx      (ridx),
        .rdata     (reg_rd),
        .live_time (live_time),
        .tick512   (tick512),
        .batt_ok   (batt_ok),
        .load_stb  (load_stb),
        .load_time (load_time),
        .osc_run   (osc_run)
    );

    AST_BATT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && clk_sel && (ridx == RI_DAY)) |-> (bus_rdata[BIT_BATT] == batt_ok)); // R10

    AST_RAM_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && clk_sel) |-> !ram_we); // R4

endmodule

// File: tb/rtc_regbus_tb_top.sv
`timescale 1ns/1ps
module rtc_regbus_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_drive;
    logic [63:0] live = 64'h2406150312304520;
    logic        tick512 = 1'b0;
    logic        batt_ok = 1'b1;
    logic        load_stb;
    logic [63:0] load_time;
    logic        osc_run;

    int total = 0;
    int bad = 0;
    int ld_cnt = 0;
    logic [63:0] ld_val = '0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_regbus dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_drive(bus_drive),
        .live_time(live), .tick512(tick512), .batt_ok(batt_ok),
        .load_stb(load_stb), .load_time(load_time), .osc_run(osc_run)
    );

    always @(posedge clk) begin
        if (load_stb) begin
            ld_cnt <= ld_cnt + 1;
            ld_val <= load_time;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [14:0] a;
        logic [7:0]  d;
        logic [3:0]  req;
    } vec_t;

    // RAM and register accesses; reads carry expected data
    localparam vec_t VT [0:9] = '{
        '{1'b1, 15'h0010, 8'hA5, 4'd4},
        '{1'b1, 15'h00F8, 8'h3C, 4'd4},
        '{1'b1, 15'h7FFE, 8'hE0, 4'd11},
        '{1'b0, 15'h0010, 8'hA5, 4'd4},
        '{1'b0, 15'h00F8, 8'h3C, 4'd4},   // R4 alias kept apart
        '{1'b0, 15'h7FFE, 8'hE6, 4'd11},  // R11 spare month bits
        '{1'b0, 15'h7FFF, 8'h24, 4'd5},   // R5 year tracks
        '{1'b1, 15'h7FF8, 8'h05, 4'd5},
        '{1'b0, 15'h7FF8, 8'h20, 4'd5},   // R5 field write overwritten
        '{1'b0, 15'h00F8, 8'h3C, 4'd4}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic drv);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = bus_rdata; drv = bus_drive;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        logic [7:0] rd;
        logic       dv;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 drive", {63'd0, bus_drive}, 64'd0);
        check("R1 rdata", {56'd0, bus_rdata}, 64'd0);
        check("R1 load_stb", {63'd0, load_stb}, 64'd0);
        check("R1 osc_run", {63'd0, osc_run}, 64'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            if (VT[i].wr) begin
                bus_write(VT[i].a, VT[i].d);
            end else begin
                bus_read(VT[i].a, rd, dv);
                check($sformatf("R%0d table read %0d", VT[i].req, i), {56'd0, rd}, {56'd0, VT[i].d});
                check("R2 drive on read", {63'd0, dv}, 64'd1);
            end
        end
        check("R7 no load without release", ld_cnt, 0);

        // R2 write with oe low: never driven; R3 commit regardless of oe_n
        @(negedge clk);
        addr = 15'h0020; wdata = 8'h77; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        #1 check("R2 no drive in write", {63'd0, bus_drive}, 64'd0);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        addr = 15'h0010; cs_n = 1'b1; oe_n = 1'b0;
        #1 check("R2 deselected rdata", {55'd0, bus_drive, bus_rdata}, 64'd0);
        oe_n = 1'b1;
        bus_read(15'h0020, rd, dv);
        check("R3 write with oe low", {56'd0, rd}, 64'h77);

        // R3 one commit per episode
        @(negedge clk);
        addr = 15'h0030; wdata = 8'h11; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk); wdata = 8'h22;
        @(negedge clk);
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
        bus_read(15'h0030, rd, dv);
        check("R3 single commit", {56'd0, rd}, 64'h11);

        // R6 read hold
        bus_write(15'h7FF8, 8'h40);
        live[15:8] = 8'h46;
        repeat (2) @(negedge clk);
        bus_read(15'h7FF9, rd, dv);
        check("R6 frozen seconds", {56'd0, rd}, 64'h45);
        bus_write(15'h7FF8, 8'h00);
        bus_read(15'h7FF9, rd, dv);
        check("R6 refreshed seconds", {56'd0, rd}, 64'h46);
        bus_read(15'h7FF8, rd, dv);
        check("R6 refreshed century", {56'd0, rd}, 64'h20);

        // R7 write hold and commit
        bus_write(15'h7FF8, 8'h80);
        bus_write(15'h7FF9, 8'h10);
        bus_write(15'h7FFA, 8'h59);
        live[23:16] = 8'h31;
        repeat (2) @(negedge clk);
        bus_read(15'h7FFA, rd, dv);
        check("R7 held minutes", {56'd0, rd}, 64'h59);
        check("R7 no load while held", ld_cnt, 0);
        bus_write(15'h7FF8, 8'h19);
        check("R7 one load", ld_cnt, 1);
        check("R7 load value", ld_val, 64'h2406150312591019);
        live = ld_val;
        repeat (2) @(negedge clk);
        bus_read(15'h7FF9, rd, dv);
        check("R7 counter loaded", {56'd0, rd}, 64'h10);

        // R8 oscillator stop
        bus_write(15'h7FF9, 8'h80);
        check("R8 osc stopped", {63'd0, osc_run}, 64'd0);
        bus_read(15'h7FF9, rd, dv);
        check("R8 stop bit reads back", {56'd0, rd}, 64'h90);

        // R9 frequency test
        bus_write(15'h7FFC, 8'h40);
        tick512 = 1'b1;
        bus_read(15'h7FF9, rd, dv);
        check("R9 no tick when stopped", {56'd0, rd}, 64'h90);
        bus_write(15'h7FF9, 8'h00);
        check("R8 osc running", {63'd0, osc_run}, 64'd1);
        bus_read(15'h7FF9, rd, dv);
        check("R9 tick high", {56'd0, rd}, 64'h11);
        tick512 = 1'b0;
        bus_read(15'h7FF9, rd, dv);
        check("R9 tick low", {56'd0, rd}, 64'h10);

        // R10 battery flag, R11 spare day bits
        bus_read(15'h7FFC, rd, dv);
        check("R10 battery good", {56'd0, rd}, 64'hC3);
        bus_write(15'h7FFC, 8'h38);
        bus_read(15'h7FFC, rd, dv);
        check("R10 R11 flag not writable, spares kept", {56'd0, rd}, 64'hBB);
        batt_ok = 1'b0;
        bus_read(15'h7FFC, rd, dv);
        check("R10 battery low", {56'd0, rd}, 64'h3B);

        check("R7 total loads", ld_cnt, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule